// File: doc/BRIEF.md
# UART RTS/CTS Flow Gate

This block automates the two hardware handshake pins of a serial port. On the receive side it compares the receive buffer fill count with a programmable halt threshold and a lower resume threshold. It raises the active-low request-to-send output when the buffer is nearly full and lowers it again only after the buffer has drained. On the transmit side it watches the active-low clear-to-send input and produces a permission level for the transmit shift engine. When the far end withdraws clear-to-send, the character already being shifted still finishes before the engine is frozen.

Each side has its own enable. With the receive side disabled, the request-to-send pin follows a software value. Any change on either pin can set a sticky interrupt flag, which a read strobe clears. The buffer level, the busy indication of the shift engine and its end-of-character strobe come from neighbouring logic as plain inputs.

Top module: `uart_flow_gate`

## Requirements
- R1: With `rts_auto_en` high, a `rx_level` at or above `halt_lvl` drives `rts_n` high on the next clock edge.
- R2: With `rts_auto_en` high and `resume_lvl` below `halt_lvl`, once `rts_n` is high it stays high while `rx_level` is above `resume_lvl`, and goes low on the edge after `rx_level` falls to `resume_lvl` or below.
- R3: When `resume_lvl` is not below `halt_lvl`, both thresholds act as `halt_lvl`: `rts_n` is high exactly when `rx_level` was at or above `halt_lvl` on the previous edge, with no hysteresis.
- R4: With `rts_auto_en` low, `rts_n` takes the value of `rts_sw_n` on the next edge, and `rx_level` has no effect on it.
- R5: `cts_n` passes through a two-stage synchronizer. With `cts_auto_en` high and `cts_n` high, `tx_allow` falls on the third edge if `tx_busy` is low. If `tx_busy` is high, `tx_allow` stays high until the edge at which `char_done` is seen.
- R6: After a halt, `tx_allow` returns high on the third edge after `cts_n` goes low again. With `cts_auto_en` low, `tx_allow` is high on the next edge.
- R7: With `irq_en` high, a change of `rts_n` or of the synchronized `cts_n` sets `irq_flag`. The flag stays set until an `irq_clr` pulse, which clears it on the next edge. A new change in the same cycle takes precedence over the clear.
- R8: With `irq_en` low, pin changes do not set `irq_flag`.
- R9: After reset, `rts_n` is high, `tx_allow` is high and `irq_flag` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rts_auto_en | input | 1 | Enables automatic request-to-send control |
| cts_auto_en | input | 1 | Enables clear-to-send transmit gating |
| rts_sw_n | input | 1 | Software value for `rts_n` when automatic control is off |
| halt_lvl | input | LVL_W | Fill count at which the far end is stopped |
| resume_lvl | input | LVL_W | Fill count at which the far end is released |
| rx_level | input | LVL_W | Current receive buffer fill count |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| tx_busy | input | 1 | Shift engine is in the middle of a character |
| char_done | input | 1 | Strobe: stop bit of the current character has been sent |
| tx_allow | output | 1 | Permission for the shift engine to run |
| rts_n | output | 1 | Request-to-send pin, active low |
| irq_en | input | 1 | Enables the pin-change interrupt |
| irq_clr | input | 1 | Read strobe that clears the interrupt flag |
| irq_flag | output | 1 | Sticky pin-change interrupt flag |

## Verification
The bench builds the block with its default depth of 64, so `LVL_W` is 7. This lets the threshold table reach a completely full buffer (level 64) and both ends of the 0 to 64 range. The table walks one fill-level sequence through the band between the two thresholds from both directions. It then swaps the thresholds so the equal-threshold fallback is exercised from the same state. Directed cases cover a halt that arrives in the middle of a character and one that arrives while the engine is idle, the release, and the interrupt with and without its enable.

// File: rtl/uart_flow_gate.sv
module uart_flow_gate #(
  parameter int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rts_auto_en,
  input  logic             cts_auto_en,
  input  logic             rts_sw_n,
  input  logic [LVL_W-1:0] halt_lvl,
  input  logic [LVL_W-1:0] resume_lvl,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             cts_n,
  input  logic             tx_busy,
  input  logic             char_done,
  output logic             tx_allow,
  output logic             rts_n,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic             irq_flag
);

  logic [LVL_W-1:0] res_eff;
  logic             full_q, full_d;
  logic             rts_q, rts_prev;
  logic             cts_m, cts_s, cts_prev;
  logic             halted;
  logic             pin_chg;

  assign res_eff = (resume_lvl < halt_lvl) ? resume_lvl : halt_lvl;

  always_comb begin
    full_d = full_q;
    if (rx_level >= halt_lvl)
      full_d = 1'b1;
    else if (rx_level <= res_eff)
      full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q   <= 1'b0;
      rts_q    <= 1'b1;
      rts_prev <= 1'b1;
    end else begin
      full_q   <= full_d;
      rts_q    <= rts_auto_en ? full_d : rts_sw_n;
      rts_prev <= rts_q;
    end
  end

  assign rts_n = rts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_m    <= 1'b1;
      cts_s    <= 1'b1;
      cts_prev <= 1'b1;
    end else begin
      cts_m    <= cts_n;
      cts_s    <= cts_m;
      cts_prev <= cts_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      halted <= 1'b0;
    else if (!cts_auto_en || !cts_s)
      halted <= 1'b0;
    else if (!tx_busy || char_done)
      halted <= 1'b1;
  end

  assign tx_allow = !halted;

  assign pin_chg = (rts_q != rts_prev) || (cts_s != cts_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq_flag <= 1'b0;
    else if (irq_en && pin_chg)
      irq_flag <= 1'b1;
    else if (irq_clr)
      irq_flag <= 1'b0;
  end

  a_r1_halt_level: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_auto_en && rx_level >= halt_lvl) |=> rts_n);

  a_r2_resume_level: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_auto_en && rx_level < halt_lvl && rx_level <= resume_lvl) |=> !rts_n);

  a_r4_soft_rts: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_auto_en |=> (rts_n == $past(rts_sw_n)));

  a_r5_whole_char: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_allow && tx_busy && !char_done) |=> tx_allow);

  a_r6_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cts_auto_en |=> tx_allow);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !irq_flag) |=> !irq_flag);

endmodule

// File: tb/tb_uart_flow_gate.sv
module tb_uart_flow_gate;
  localparam int DEPTH = 64;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rts_auto_en = 1'b0, cts_auto_en = 1'b0, rts_sw_n = 1'b1;
  logic [LVL_W-1:0] halt_lvl = '0, resume_lvl = '0, rx_level = '0;
  logic cts_n = 1'b0, tx_busy = 1'b0, char_done = 1'b0;
  logic irq_en = 1'b0, irq_clr = 1'b0;
  logic tx_allow, rts_n, irq_flag;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  uart_flow_gate #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .rts_auto_en(rts_auto_en), .cts_auto_en(cts_auto_en),
    .rts_sw_n(rts_sw_n), .halt_lvl(halt_lvl), .resume_lvl(resume_lvl), .rx_level(rx_level),
    .cts_n(cts_n), .tx_busy(tx_busy), .char_done(char_done), .tx_allow(tx_allow),
    .rts_n(rts_n), .irq_en(irq_en), .irq_clr(irq_clr), .irq_flag(irq_flag)
  );

  // fields: halt, resume, level, expected rts_n
  localparam int NV = 13;
  localparam logic [21:0] VEC [NV] = '{
    {7'd48, 7'd16, 7'd0,  1'b0},
    {7'd48, 7'd16, 7'd47, 1'b0},
    {7'd48, 7'd16, 7'd48, 1'b1},
    {7'd48, 7'd16, 7'd30, 1'b1},
    {7'd48, 7'd16, 7'd17, 1'b1},
    {7'd48, 7'd16, 7'd16, 1'b0},
    {7'd48, 7'd16, 7'd30, 1'b0},
    {7'd48, 7'd16, 7'd64, 1'b1},
    {7'd20, 7'd30, 7'd19, 1'b0},
    {7'd20, 7'd30, 7'd20, 1'b1},
    {7'd20, 7'd30, 7'd25, 1'b1},
    {7'd20, 7'd30, 7'd19, 1'b0},
    {7'd20, 7'd20, 7'd21, 1'b1}
  };

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #5;
    end
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    fork
      begin
        step(5000);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    join_none

    step(2);
    // R9 reset state
    chk("R9 rts_n", rts_n, 1'b1);
    chk("R9 tx_allow", tx_allow, 1'b1);
    chk("R9 irq_flag", irq_flag, 1'b0);
    rst_n = 1'b1;
    step(3);

    // R1 R2 R3 threshold table
    rts_auto_en = 1'b1;
    for (int v = 0; v < NV; v++) begin
      halt_lvl   = VEC[v][21:15];
      resume_lvl = VEC[v][14:8];
      rx_level   = VEC[v][7:1];
      step(1);
      chk($sformatf("R1/R2/R3 vector %0d", v), rts_n, VEC[v][0]);
    end

    // R4 software control, level ignored
    rx_level = 7'd0; step(1);
    rts_auto_en = 1'b0; rts_sw_n = 1'b0; rx_level = 7'd64; halt_lvl = 7'd10;
    step(1);
    chk("R4 soft low with full level", rts_n, 1'b0);
    rts_sw_n = 1'b1; rx_level = 7'd0;
    step(1);
    chk("R4 soft high with empty level", rts_n, 1'b1);

    // R5 halt mid-character waits for char_done
    cts_auto_en = 1'b1; tx_busy = 1'b1; cts_n = 1'b1;
    step(4);
    chk("R5 busy keeps tx_allow", tx_allow, 1'b1);
    char_done = 1'b1; step(1); char_done = 1'b0; tx_busy = 1'b0;
    chk("R5 halt at char boundary", tx_allow, 1'b0);

    // R6 release
    cts_n = 1'b0;
    step(2);
    chk("R6 still halted after 2 edges", tx_allow, 1'b0);
    step(1);
    chk("R6 released after 3 edges", tx_allow, 1'b1);

    // R5 idle halt
    cts_n = 1'b1;
    step(2);
    chk("R5 idle not yet halted", tx_allow, 1'b1);
    step(1);
    chk("R5 idle halt", tx_allow, 1'b0);

    // R6 gating disabled
    cts_auto_en = 1'b0;
    step(1);
    chk("R6 gating off", tx_allow, 1'b1);

    // R8 disabled interrupt: cts went high earlier with irq_en low
    chk("R8 no flag while masked", irq_flag, 1'b0);
    cts_n = 1'b0; step(4);
    chk("R8 no flag after masked change", irq_flag, 1'b0);

    // R7 interrupt on cts change
    irq_en = 1'b1; cts_n = 1'b1;
    step(2);
    chk("R7 flag not before sync", irq_flag, 1'b0);
    step(1);
    chk("R7 flag on cts change", irq_flag, 1'b1);
    step(3);
    chk("R7 flag sticky", irq_flag, 1'b1);
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    chk("R7 flag cleared", irq_flag, 1'b0);

    // R7 interrupt on rts change
    rts_sw_n = 1'b0;
    step(2);
    chk("R7 flag on rts change", irq_flag, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule